// File: doc/BRIEF.md
# Redundant Dual-Line Clock Role Controller

This block decides the clocking role of one node on a shared bus that carries two redundant clock lines. One is the right (primary) line and the other is the left (fallback) line. A seven-state machine chooses whether the node drives the right line, drives the left line, or drives neither. It acts on presence flags for both lines, a local-reference-good flag, a secondary-side viability flag and single-cycle host commands. The host can ask for master, slave or fallback-master operation.

A node moves into a driving role only after passing through a waiting state. That waiting state confirms that the line is absent, or that a peer has taken over. As a result, the node never puts a clock on a line that another node already supplies. Clock presence detection and PLL source selection sit outside this block. The state code and both drive enables are registered and change on the same clock edge.

Top module: `clk_role_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, the state is Slave and neither drive enable is set. The state codes are Slave=0, Master=1, Wait Master=2, Wait Slave=3, Fallback Master=4, Wait Fallback Master=5 and Wait Fallback Slave=6.
- R2: Only Master (1) and Wait Slave (3) set the right drive. Only Fallback Master (4) and Wait Fallback Slave (6) set the left drive. The drives never assert together, and they change on the same edge as the state.
- R3: Master moves to Wait Slave on any of three conditions: the reference flag is low, the viability flag is low, or a slave command arrives.
- R4: Wait Slave moves to Slave when the left line is present. If the left line is absent and both the reference and viability flags are high, it moves to Wait Master. Otherwise it holds.
- R5: Wait Master moves to Master only when the right line is absent. It holds while the right line is present.
- R6: Fallback Master ignores both line flags and holds until a slave command arrives. That command moves it to Wait Fallback Slave.
- R7: Wait Fallback Slave moves to Slave when the right line is present.
- R8: Wait Fallback Master moves to Fallback Master only when the left line is absent.
- R9: Slave has no automatic exit. A master command moves it to Wait Master, and a fallback-master command moves it to Wait Fallback Master.
- R10: Each command is accepted only in certain states and is ignored in all others, leaving the state unchanged:
  - master: Slave and Wait Fallback Master, leading to Wait Master;
  - fallback-master: Slave, Wait Master and Wait Fallback Slave, leading to Wait Fallback Master;
  - slave: Master and Fallback Master.
- R11: An accepted command takes priority over any presence-based move in the same cycle. When several commands are accepted together, master beats fallback-master, and fallback-master beats slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_master | input | 1 | Single-cycle master command |
| cmd_slave | input | 1 | Single-cycle slave command |
| cmd_fbm | input | 1 | Single-cycle fallback-master command |
| right_present | input | 1 | Right line is carrying a clock |
| left_present | input | 1 | Left line is carrying a clock |
| ref_good | input | 1 | Local clock reference is good |
| side_viable | input | 1 | Secondary side can support mastership |
| drive_right | output | 1 | Drive enable for the right line |
| drive_left | output | 1 | Drive enable for the left line |
| role_state | output | 3 | Current state code |

## Verification
The hardest cases to reach are cycles where an accepted command collides with an automatic move. Two examples are a fallback-master command arriving in Wait Fallback Slave while the right line returns, and a master command arriving in Wait Fallback Master while the left line vanishes. Each case needs a multi-step walk through the waiting states to reach the right state first. The vector table chains the states so that every vector starts from where the previous one ended. It uses that chain to reach Wait Slave held by a failed reference, where commands must be ignored, and to reach Slave with two commands pulsed together.

// File: rtl/role_pkg.sv
package role_pkg;
  localparam int STATE_W = 3;
  localparam int CMD_N   = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_SLAVE          = 3'd0,
    ST_MASTER         = 3'd1,
    ST_WAIT_MASTER    = 3'd2,
    ST_WAIT_SLAVE     = 3'd3,
    ST_FB_MASTER      = 3'd4,
    ST_WAIT_FB_MASTER = 3'd5,
    ST_WAIT_FB_SLAVE  = 3'd6
  } role_e;

  // index of each command in the request vector; lower index wins
  localparam int CI_MASTER = 0;
  localparam int CI_FBM    = 1;
  localparam int CI_SLAVE  = 2;
endpackage

// File: rtl/role_cmd_filter.sv
module role_cmd_filter
  import role_pkg::*;
(
  input  role_e              cur,
  input  logic [CMD_N-1:0]   req,
  output logic [CMD_N-1:0]   grant
);
  logic [CMD_N-1:0] legal;
  logic [CMD_N-1:0] acc;

  always_comb begin
    legal = '0;
    legal[CI_MASTER] = (cur == ST_SLAVE) || (cur == ST_WAIT_FB_MASTER);
    legal[CI_FBM]    = (cur == ST_SLAVE) || (cur == ST_WAIT_MASTER) ||
                       (cur == ST_WAIT_FB_SLAVE);
    legal[CI_SLAVE]  = (cur == ST_MASTER) || (cur == ST_FB_MASTER);
    acc = req & legal;
  end

  // fixed priority: the lowest index among the accepted requests wins
  genvar g;
  generate
    for (g = 0; g < CMD_N; g++) begin : g_pri
      if (g == 0) begin : g_top
        assign grant[g] = acc[g];
      end else begin : g_rest
        assign grant[g] = acc[g] && (acc[g-1:0] == '0);
      end
    end
  endgenerate

  always_comb begin
    assert_grant_onehot_R11: assert ($onehot0(grant));
  end
endmodule

// File: rtl/role_next_state.sv
module role_next_state
  import role_pkg::*;
(
  input  role_e            cur,
  input  logic [CMD_N-1:0] grant,
  input  logic             right_present,
  input  logic             left_present,
  input  logic             ref_good,
  input  logic             side_viable,
  output role_e            nxt
);
  always_comb begin
    nxt = cur;
    unique case (cur)
      ST_SLAVE: begin
        if (grant[CI_MASTER])   nxt = ST_WAIT_MASTER;
        else if (grant[CI_FBM]) nxt = ST_WAIT_FB_MASTER;
      end
      ST_MASTER: begin
        if (grant[CI_SLAVE] || !ref_good || !side_viable) nxt = ST_WAIT_SLAVE;
      end
      ST_WAIT_SLAVE: begin
        if (left_present)                nxt = ST_SLAVE;
        else if (ref_good && side_viable) nxt = ST_WAIT_MASTER;
      end
      ST_WAIT_MASTER: begin
        if (grant[CI_FBM])      nxt = ST_WAIT_FB_MASTER;
        else if (!right_present) nxt = ST_MASTER;
      end
      ST_FB_MASTER: begin
        if (grant[CI_SLAVE]) nxt = ST_WAIT_FB_SLAVE;
      end
      ST_WAIT_FB_SLAVE: begin
        if (grant[CI_FBM])      nxt = ST_WAIT_FB_MASTER;
        else if (right_present) nxt = ST_SLAVE;
      end
      ST_WAIT_FB_MASTER: begin
        if (grant[CI_MASTER])   nxt = ST_WAIT_MASTER;
        else if (!left_present) nxt = ST_FB_MASTER;
      end
      default: nxt = ST_SLAVE;
    endcase
  end
endmodule

// File: rtl/role_state_reg.sv
module role_state_reg
  import role_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  role_e nxt,
  output role_e cur,
  output logic  drv_r,
  output logic  drv_l
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur   <= ST_SLAVE;
      drv_r <= 1'b0;
      drv_l <= 1'b0;
    end else begin
      cur   <= nxt;
      drv_r <= (nxt == ST_MASTER) || (nxt == ST_WAIT_SLAVE);
      drv_l <= (nxt == ST_FB_MASTER) || (nxt == ST_WAIT_FB_SLAVE);
    end
  end

  assert_right_match_R2: assert property (@(posedge clk) disable iff (rst)
    drv_r == ((cur == ST_MASTER) || (cur == ST_WAIT_SLAVE)));
  assert_left_match_R2: assert property (@(posedge clk) disable iff (rst)
    drv_l == ((cur == ST_FB_MASTER) || (cur == ST_WAIT_FB_SLAVE)));
  assert_never_both_R2: assert property (@(posedge clk) disable iff (rst)
    !(drv_r && drv_l));
endmodule

// File: rtl/clk_role_ctrl.sv
module clk_role_ctrl
  import role_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_master,
  input  logic               cmd_slave,
  input  logic               cmd_fbm,
  input  logic               right_present,
  input  logic               left_present,
  input  logic               ref_good,
  input  logic               side_viable,
  output logic               drive_right,
  output logic               drive_left,
  output logic [STATE_W-1:0] role_state
);
  role_e            cur;
  role_e            nxt;
  logic [CMD_N-1:0] req;
  logic [CMD_N-1:0] grant;

  always_comb begin
    req            = '0;
    req[CI_MASTER] = cmd_master;
    req[CI_FBM]    = cmd_fbm;
    req[CI_SLAVE]  = cmd_slave;
  end

  role_cmd_filter u_filter (
    .cur   (cur),
    .req   (req),
    .grant (grant)
  );

  role_next_state u_next (
    .cur           (cur),
    .grant         (grant),
    .right_present (right_present),
    .left_present  (left_present),
    .ref_good      (ref_good),
    .side_viable   (side_viable),
    .nxt           (nxt)
  );

  role_state_reg u_reg (
    .clk   (clk),
    .rst   (rst),
    .nxt   (nxt),
    .cur   (cur),
    .drv_r (drive_right),
    .drv_l (drive_left)
  );

  assign role_state = cur;

  assert_no_right_takeover_R5: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_WAIT_MASTER && right_present) |=> (cur != ST_MASTER));
  assert_no_left_takeover_R8: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_WAIT_FB_MASTER && left_present) |=> (cur != ST_FB_MASTER));
  assert_fbm_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_FB_MASTER && !cmd_slave) |=> (cur == ST_FB_MASTER));
  assert_slave_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_SLAVE && !cmd_master && !cmd_fbm) |=> (cur == ST_SLAVE));
  assert_wait_slave_cmds_R10: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_WAIT_SLAVE && !left_present && !ref_good) |=> (cur == ST_WAIT_SLAVE));
endmodule

// File: tb/clk_role_ctrl_tb.sv
module clk_role_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_master = 1'b0, cmd_slave = 1'b0, cmd_fbm = 1'b0;
  logic right_present = 1'b1, left_present = 1'b1, ref_good = 1'b1, side_viable = 1'b1;
  logic drive_right, drive_left;
  logic [2:0] role_state;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  clk_role_ctrl u_dut (
    .clk(clk), .rst(rst),
    .cmd_master(cmd_master), .cmd_slave(cmd_slave), .cmd_fbm(cmd_fbm),
    .right_present(right_present), .left_present(left_present),
    .ref_good(ref_good), .side_viable(side_viable),
    .drive_right(drive_right), .drive_left(drive_left),
    .role_state(role_state)
  );

  // {cmd_master, cmd_slave, cmd_fbm, right, left, ref, viable, expected state}
  localparam logic [9:0] VEC [32] = '{
    10'b000_1111_000, 10'b010_1111_000, 10'b100_1111_010, 10'b000_1111_010,
    10'b000_0111_001, 10'b000_0111_001, 10'b000_0101_011, 10'b000_0001_011,
    10'b000_0011_010, 10'b001_1111_101, 10'b000_1111_101, 10'b000_1011_100,
    10'b100_1011_100, 10'b010_1111_110, 10'b000_0111_110, 10'b001_1111_101,
    10'b100_1011_010, 10'b001_0111_101, 10'b000_1011_100, 10'b010_1111_110,
    10'b000_1111_000, 10'b100_1111_010, 10'b000_0111_001, 10'b000_0010_011,
    10'b000_1111_000, 10'b100_1111_010, 10'b000_0111_001, 10'b010_0011_011,
    10'b101_0001_011, 10'b000_1111_000, 10'b101_1111_010, 10'b011_1111_101
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 2:              return "R9";
      1, 12, 28:         return "R10";
      3, 4, 9, 21, 22:   return "R5";
      5, 6, 23, 25, 26, 27: return "R3";
      7, 8, 24, 29:      return "R4";
      10, 11, 18:        return "R8";
      13, 19:            return "R6";
      14, 20:            return "R7";
      default:           return "R11";
    endcase
  endfunction

  // expected {state, right drive, left drive} from the R2 decode
  function automatic logic [4:0] expect_of(logic [2:0] st);
    logic r, l;
    r = (st == 3'd1) || (st == 3'd3);
    l = (st == 3'd4) || (st == 3'd6);
    return {st, r, l};
  endfunction

  task automatic check(string tag, logic [4:0] exp);
    logic [4:0] act;
    act = {role_state, drive_right, drive_left};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (R2 drives): got state=%0d r=%0b l=%0b expected state=%0d r=%0b l=%0b",
               tag, act[4:2], act[1], act[0], exp[4:2], exp[1], exp[0]);
    end
  endtask

  task automatic apply(logic [6:0] in);
    @(negedge clk);
    {cmd_master, cmd_slave, cmd_fbm, right_present, left_present, ref_good, side_viable} = in;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 during reset", expect_of(3'd0));
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R1 after reset", expect_of(3'd0));

    for (int i = 0; i < 32; i++) begin
      apply(VEC[i][9:3]);
      check(vec_tag(i), expect_of(VEC[i][2:0]));
    end

    // drive to Master, then reset mid-operation
    apply(7'b100_1111);
    check("R9 to wait master", expect_of(3'd2));
    apply(7'b000_0111);
    check("R5 to master", expect_of(3'd1));
    @(negedge clk);
    {cmd_master, cmd_slave, cmd_fbm} = 3'b000;
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 reset from master", expect_of(3'd0));
    @(negedge clk);
    rst = 1'b0;
    apply(7'b000_0000);
    check("R9 slave no automatic exit", expect_of(3'd0));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule